// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Vector Generation

This block collects interrupt requests from several groups of up to 31 sources each. Every source pulse is caught in a sticky status bit and gated by a per-source enable. Each group is set up through its own control word, which holds a mode bit and a vector base. In spread mode, every enabled pending source in the group competes on its own, using its own 2-bit priority field. In that mode the block hands the processor a vector equal to the group base plus eight bytes per source index. In collapsed mode, the whole group folds into one competitor at index 0. That competitor vectors to the group base and uses the priority field of source 0.

A single priority decision runs over every competitor from all groups. The highest requested level wins. On a tie, the lowest flattened index wins, and group 0 comes before group 1. The request, vector and level outputs are registered. Software configures the block through a write-only port. Each write selects a group and a register code.

Top module: `aggr_top`

## Requirements
- R1: A source input high at a clock edge sets its status bit, which stays set until a write of 1 to that bit at register code 0 clears it; a source high in the same cycle as the clearing write keeps the bit set.
- R2: Writing 1s at code 1 sets enable bits and writing 1s at code 2 clears them; only sources both pending and enabled can request, and a pending but disabled source keeps its status and requests once re-enabled.
- R3: At code 3, data bit 0 set selects spread mode and clear selects collapsed mode; data bits 17:1 form the vector base, whose bit 0 is always zero (0x501 gives spread mode with base 0x500).
- R4: In spread mode the vector of source index i is base + 8*i (base 0x500: index 2 gives 0x510, index 29 gives 0x5E8).
- R5: In collapsed mode any enabled pending source of the group yields one competitor with vector equal to the base and the priority field of source 0.
- R6: The requested level is the 2-bit priority field plus 1 (levels 1 to 4); the field of source i lies at code 4 bits 2i+1:2i for i below 16, and at code 5 bits 2(i-16)+1:2(i-16) otherwise.
- R7: The highest level wins; among equal levels the lowest index wins, and all group 0 competitors precede group 1.
- R8: Outputs follow the status and configuration registers one clock later; with no competitor, the request, vector and level are all zero.
- R9: Asserting reset clears all status, enable, control and priority state and drives all outputs to zero at once; its release takes effect after two clock edges.
- R10: Register writes address the group in wr_addr[3] and the register code in wr_addr[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Group (bit 3) and register code (bits 2:0) |
| wr_data | input | 32 | Register write data |
| src_in | input | 62 | Source requests, group 0 in bits 30:0, group 1 in bits 61:31 |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 19 | Vector address of the winner |
| irq_lvl | output | 3 | Requested priority level of the winner |

## Verification
The assertions rely on a few limits on the inputs. Only one register write happens per cycle. No writes arrive while reset is held. Source pulses and writes change away from the clock edge. The bench keeps within these limits by driving every input at the falling edge, one write per task call. It uses only register codes 0 to 5 and waits out the two-edge reset release before it configures anything. Priority and ordering are tested with chosen sets of simultaneous pulses whose winners are worked out from R6 and R7.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int REG_W     = 3;
  localparam int DATA_W    = 32;
  localparam int MODE_BIT  = 0;
  localparam int BASE_LSB  = 1;
  localparam int BASE_MSB  = 17;
  localparam int CTRL_W    = BASE_MSB + 1;
  localparam int SPC_SH    = 3;

  localparam logic [REG_W-1:0] RC_STAT  = 3'd0;
  localparam logic [REG_W-1:0] RC_ENSET = 3'd1;
  localparam logic [REG_W-1:0] RC_ENCLR = 3'd2;
  localparam logic [REG_W-1:0] RC_CTRL  = 3'd3;
  localparam logic [REG_W-1:0] RC_PRIO  = 3'd4;
endpackage

// File: rtl/aggr_group.sv
module aggr_group
  import aggr_pkg::*;
#(
  parameter int SRC    = 31,
  parameter int PW     = 2,
  parameter int GRP_W  = 1,
  parameter int GRP_ID = 0,
  localparam int AW    = GRP_W + REG_W,
  localparam int FPW   = DATA_W / PW,
  localparam int NWORD = (SRC + FPW - 1) / FPW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SRC-1:0]    src_in,
  output logic [SRC-1:0]    res_act,
  output logic [SRC*PW-1:0] res_prio,
  output logic [CTRL_W-1:0] base
);
  logic [REG_W-1:0]  code;
  logic              hit;
  logic              stat_we, enset_we, enclr_we, ctrl_we;
  logic [NWORD-1:0]  prio_we;

  logic [SRC-1:0]    st_q, st_d, en_q, en_d, pend;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [SRC*PW-1:0] prio_q, prio_d;
  logic              st_ce, en_ce, ctrl_ce, prio_ce;

  assign code     = wr_addr[REG_W-1:0];
  assign hit      = wr_en && (wr_addr[AW-1:REG_W] == GRP_W'(GRP_ID));
  assign stat_we  = hit && (code == RC_STAT);
  assign enset_we = hit && (code == RC_ENSET);
  assign enclr_we = hit && (code == RC_ENCLR);
  assign ctrl_we  = hit && (code == RC_CTRL);

  for (genvar w = 0; w < NWORD; w++) begin : g_pwe
    assign prio_we[w] = hit && (code == RC_PRIO + REG_W'(w));
  end

  // next state
  always_comb begin
    st_d    = (st_q & ~(stat_we ? wr_data[SRC-1:0] : '0)) | src_in;
    st_ce   = stat_we | (|src_in);
    en_d    = en_q;
    if (enset_we) en_d = en_q | wr_data[SRC-1:0];
    if (enclr_we) en_d = en_q & ~wr_data[SRC-1:0];
    en_ce   = enset_we | enclr_we;
    ctrl_d  = wr_data[CTRL_W-1:0];
    ctrl_ce = ctrl_we;
    prio_ce = |prio_we;
  end

  for (genvar i = 0; i < SRC; i++) begin : g_prio
    assign prio_d[i*PW +: PW] = prio_we[i/FPW] ? wr_data[(i%FPW)*PW +: PW]
                                               : prio_q[i*PW +: PW];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
      prio_q <= '0;
    end else begin
      if (st_ce)   st_q   <= st_d;
      if (en_ce)   en_q   <= en_d;
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (prio_ce) prio_q <= prio_d;
    end
  end

  // result shaping per mode
  always_comb begin
    pend = st_q & en_q;
    if (ctrl_q[MODE_BIT]) begin
      res_act = pend;
    end else begin
      res_act    = '0;
      res_act[0] = |pend;
    end
  end

  assign res_prio = prio_q;
  assign base     = {ctrl_q[BASE_MSB:BASE_LSB], 1'b0};

  // R1: without a clearing write, no status bit falls
  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R1: a clearing write drops the bit unless its source is high
  a_r1_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> ((st_q & $past(wr_data[SRC-1:0]) & ~$past(src_in)) == '0));

  // R2: set-enable write leaves every written 1 enabled
  a_r2_enset: assert property (@(posedge clk) disable iff (!rst_n)
    enset_we |=> ((en_q & $past(wr_data[SRC-1:0])) == $past(wr_data[SRC-1:0])));
endmodule

// File: rtl/aggr_pick.sv
module aggr_pick
  import aggr_pkg::*;
#(
  parameter int NG     = 2,
  parameter int SRC    = 31,
  parameter int PW     = 2,
  parameter int BASE_W = CTRL_W,
  parameter int VEC_W  = CTRL_W + 1,
  localparam int N     = NG * SRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      cand_act,
  input  logic [N*PW-1:0]   cand_prio,
  input  logic [NG*BASE_W-1:0] grp_base,
  output logic              pick_valid,
  output logic [VEC_W-1:0]  pick_vec,
  output logic [PW:0]       pick_lvl
);
  logic          found;
  logic [PW-1:0] best;
  int            wg, wb, win_idx;

  // linear scan: strict greater keeps the lowest index on ties
  always_comb begin
    found = 1'b0;
    best  = '0;
    wg    = 0;
    wb    = 0;
    for (int g = 0; g < NG; g++) begin
      for (int b = 0; b < SRC; b++) begin
        if (cand_act[g*SRC+b] &&
            (!found || (cand_prio[(g*SRC+b)*PW +: PW] > best))) begin
          found = 1'b1;
          best  = cand_prio[(g*SRC+b)*PW +: PW];
          wg    = g;
          wb    = b;
        end
      end
    end
    win_idx    = wg * SRC + wb;
    pick_valid = found;
    pick_vec   = found ? (VEC_W'(grp_base[wg*BASE_W +: BASE_W]) + (VEC_W'(wb) << SPC_SH))
                       : '0;
    pick_lvl   = found ? ((PW+1)'(best) + (PW+1)'(1)) : '0;
  end

  // R7: the chosen competitor is one that is actually active
  a_r7_win_active: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> cand_act[win_idx]);
endmodule

// File: rtl/aggr_top.sv
module aggr_top
  import aggr_pkg::*;
#(
  parameter int NUM_GROUPS    = 2,
  parameter int SRC_PER_GROUP = 31,
  parameter int PRIO_W        = 2,
  localparam int GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W = GRP_W + REG_W,
  localparam int NSRC   = NUM_GROUPS * SRC_PER_GROUP,
  localparam int VEC_W  = CTRL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [PRIO_W:0]   irq_lvl
);
  logic rst_meta, rst_s;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [NSRC-1:0]              cand_act;
  logic [NSRC*PRIO_W-1:0]       cand_prio;
  logic [NUM_GROUPS*CTRL_W-1:0] grp_base;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    aggr_group #(
      .SRC    (SRC_PER_GROUP),
      .PW     (PRIO_W),
      .GRP_W  (GRP_W),
      .GRP_ID (g)
    ) u_grp (
      .clk      (clk),
      .rst_n    (rst_s),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .src_in   (src_in[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
      .res_act  (cand_act[g*SRC_PER_GROUP +: SRC_PER_GROUP]),
      .res_prio (cand_prio[g*SRC_PER_GROUP*PRIO_W +: SRC_PER_GROUP*PRIO_W]),
      .base     (grp_base[g*CTRL_W +: CTRL_W])
    );
  end

  logic              pick_valid;
  logic [VEC_W-1:0]  pick_vec;
  logic [PRIO_W:0]   pick_lvl;

  aggr_pick #(
    .NG     (NUM_GROUPS),
    .SRC    (SRC_PER_GROUP),
    .PW     (PRIO_W),
    .BASE_W (CTRL_W),
    .VEC_W  (VEC_W)
  ) u_pick (
    .clk        (clk),
    .rst_n      (rst_s),
    .cand_act   (cand_act),
    .cand_prio  (cand_prio),
    .grp_base   (grp_base),
    .pick_valid (pick_valid),
    .pick_vec   (pick_vec),
    .pick_lvl   (pick_lvl)
  );

  logic             req_d, req_q;
  logic [VEC_W-1:0] vec_d, vec_q;
  logic [PRIO_W:0]  lvl_d, lvl_q;
  logic             out_ce;

  always_comb begin
    req_d  = pick_valid;
    vec_d  = pick_vec;
    lvl_d  = pick_lvl;
    out_ce = (req_d != req_q) || (vec_d != vec_q) || (lvl_d != lvl_q);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q <= 1'b0;
      vec_q <= '0;
      lvl_q <= '0;
    end else if (out_ce) begin
      req_q <= req_d;
      vec_q <= vec_d;
      lvl_q <= lvl_d;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;
  assign irq_lvl = lvl_q;

  // R8: idle outputs are all zero
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_s)
    !irq_req |-> ((irq_vec == '0) && (irq_lvl == '0)));

  // R6: a raised request never carries level 0
  a_r6_level_nonzero: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> (irq_lvl != '0));

  // R8: request follows group results one clock later
  a_r8_req_follow: assert property (@(posedge clk) disable iff (!rst_s)
    (|cand_act) |=> irq_req);
  a_r8_req_drop: assert property (@(posedge clk) disable iff (!rst_s)
    !(|cand_act) |=> !irq_req);
endmodule

// File: tb/aggr_top_bench.sv
module aggr_top_bench;
  logic        clk, rst_n, wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [61:0] src_in;
  logic        irq_req;
  logic [18:0] irq_vec;
  logic [2:0]  irq_lvl;
  int checks = 0, errors = 0;

  aggr_top u_aggr_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_in(src_in), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {g0 pulse, g1 pulse, req, vec, lvl}
  localparam int NT = 15;
  localparam logic [84:0] TBL [NT] = '{
    {31'h2000_0000, 31'h0, 1'b1, 19'h005E8, 3'd1},  // R4 idx 29
    {31'h0000_0004, 31'h0, 1'b1, 19'h00510, 3'd1},  // R4 idx 2
    {31'h2000_0004, 31'h0, 1'b1, 19'h00510, 3'd1},  // R7 tie lowest
    {31'h0000_0001, 31'h0, 1'b1, 19'h00500, 3'd1},  // R4 idx 0
    {31'h0000_00A0, 31'h0, 1'b1, 19'h00528, 3'd3},  // R7 tie at level 3
    {31'h2000_0020, 31'h0, 1'b1, 19'h00528, 3'd3},  // R7 higher beats lower
    {31'h4000_0020, 31'h0, 1'b1, 19'h005F0, 3'd4},  // R6 high word field
    {31'h0000_0400, 31'h0, 1'b0, 19'h00000, 3'd0},  // R2 disabled source
    {31'h0000_0404, 31'h0, 1'b1, 19'h00510, 3'd1},  // R2 disabled loses
    {31'h0, 31'h0002_0000, 1'b1, 19'h00800, 3'd2},  // R5 collapsed group
    {31'h0000_0004, 31'h0000_0008, 1'b1, 19'h00800, 3'd2}, // R7 across groups
    {31'h0000_0020, 31'h0000_0001, 1'b1, 19'h00528, 3'd3}, // R7 group 0 higher
    {31'h0000_0002, 31'h0000_0001, 1'b1, 19'h00508, 3'd2}, // R7 cross tie
    {31'h0, 31'h0, 1'b0, 19'h00000, 3'd0},          // R8 idle
    {31'h0, 31'h7FFF_FFFF, 1'b1, 19'h00800, 3'd2}   // R5 all sources
  };

  task automatic chk(input string tag, input logic [18:0] ev,
                     input logic er, input logic [2:0] el);
    checks++;
    if (irq_req !== er || irq_vec !== ev || irq_lvl !== el) begin
      errors++;
      $display("FAIL %s act req=%0b vec=%h lvl=%0d exp req=%0b vec=%h lvl=%0d",
               tag, irq_req, irq_vec, irq_lvl, er, ev, el);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_all();
    wr(4'd0, 32'h7FFF_FFFF);
    wr(4'd8, 32'h7FFF_FFFF);
  endtask

  task automatic pulse(input logic [61:0] p);
    src_in = p;
    @(negedge clk);
    src_in = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; src_in = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset state", 19'h0, 1'b0, 3'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 setup: group in addr bit 3, code in bits 2:0
    wr(4'd3,  32'h0000_0501);   // R3 group 0 spread, base 0x500
    wr(4'd11, 32'h0000_0800);   // R3 group 1 collapsed, base 0x800
    wr(4'd4,  32'h0000_8804);   // R6 src1=1 src5=2 src7=2
    wr(4'd5,  32'h3000_0000);   // R6 src30=3
    wr(4'd12, 32'h0000_0001);   // R6 group 1 src0=1
    wr(4'd1,  32'hFFFF_FFFF);   // R2 enable all
    wr(4'd2,  32'h0000_0400);   // R2 disable src10
    wr(4'd9,  32'hFFFF_FFFF);
    chk("R2 no pending after setup", 19'h0, 1'b0, 3'd0);

    for (int i = 0; i < NT; i++) begin
      clear_all();
      pulse({TBL[i][53:23], TBL[i][84:54]});
      chk($sformatf("R7 table entry %0d", i), TBL[i][21:3], TBL[i][22], TBL[i][2:0]);
    end

    // R8 latency and R1 stickiness
    clear_all();
    @(negedge clk);
    src_in = 62'(1) << 29;
    @(negedge clk);
    src_in = '0;
    chk("R8 not yet visible", 19'h0, 1'b0, 3'd0);
    @(negedge clk);
    chk("R8 visible next cycle", 19'h005E8, 1'b1, 3'd1);
    repeat (5) @(negedge clk);
    chk("R1 sticky hold", 19'h005E8, 1'b1, 3'd1);

    // R1 clear by write of 1
    wr(4'd0, 32'h2000_0000);
    @(negedge clk);
    chk("R1 cleared", 19'h0, 1'b0, 3'd0);

    // R1 source beats clear in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'h4; src_in = 62'h4;
    @(negedge clk);
    wr_en = 1'b0; src_in = '0;
    @(negedge clk);
    chk("R1 set wins", 19'h00510, 1'b1, 3'd1);

    // R2 disable hides, re-enable restores
    wr(4'd2, 32'h4);
    @(negedge clk);
    chk("R2 disabled pending", 19'h0, 1'b0, 3'd0);
    wr(4'd1, 32'h4);
    @(negedge clk);
    chk("R2 re-enabled", 19'h00510, 1'b1, 3'd1);

    // R5 switch group 0 to collapsed
    wr(4'd3, 32'h0000_0500);
    @(negedge clk);
    chk("R5 collapsed base", 19'h00500, 1'b1, 3'd1);
    pulse(62'h20);
    chk("R5 uses source 0 field", 19'h00500, 1'b1, 3'd1);
    wr(4'd3, 32'h0000_0501);
    @(negedge clk);
    chk("R3 back to spread", 19'h00528, 1'b1, 3'd3);
    wr(4'd3, 32'h0003_FFFF);
    @(negedge clk);
    chk("R3 full base", 19'h40026, 1'b1, 3'd3);

    // R9 mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", 19'h0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 state cleared", 19'h0, 1'b0, 3'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule